// File: doc/BRIEF.md
# Serial ADC Channel Reader

This block performs a single conversion read from an analog-to-digital converter that sits on an SPI link and uses an 8-bit word. A requester supplies a 3-bit channel number through a valid/ready handshake. The block then takes the converter's select line low and waits a programmable settling interval. Next it clocks three bytes through its own mode-0 shifter: a control byte built from the channel, then two zero bytes. Select stays low throughout. The reply to the first byte is thrown away. The conversion value is spread across the replies to the second and third bytes. Bit positions in those two replies that must read as zero are checked to catch a corrupted read.

The request side follows valid/ready rules. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester may hold `req_valid` and `req_chan` for as long as it likes, and nothing is taken while `req_ready` is low. The result side has no back-pressure. `rd_done` is a one-cycle pulse, and `rd_value` and `rd_err` are valid in that cycle and keep their values until the next read finishes. The SPI clock rate is set by a divider parameter, and the select-to-first-edge delay is set by a cycle-count parameter.

Top module: `adc_chan_reader`

## Requirements
- R1: While reset is asserted and after it is released: `spi_cs_n`=1, `spi_sclk`=0, `req_ready`=1, `rd_done`=0.
- R2: The first byte sent is {1, channel[2:0], 1111}, i.e. bits 7 and 3..0 set with the channel in bits 6..4. It is followed by 0x00 and 0x00. Each byte goes out MSB first.
- R3: SPI mode 0. `spi_sclk` idles low and `spi_mosi` holds steady while `spi_sclk` is high. `spi_miso` is sampled on the rising edge. Each read has exactly 24 rising edges.
- R4: `spi_cs_n` is active low and idles high. It stays low from acceptance until the last falling edge of the third byte, and `spi_sclk` is low whenever `spi_cs_n` is high.
- R5: At least SETUP_CYC clock cycles pass between `spi_cs_n` going low and the first rising edge of `spi_sclk`.
- R6: The reply to the first byte is discarded. With second reply B and third reply C, the value is {B[5:0], C[7:6]}.
- R7: `rd_err` is set when B[7:6] or C[5:0] is nonzero. In that case `rd_value` is 0.
- R8: `rd_done` is high for exactly one cycle. That cycle is the first one with `spi_cs_n` high again, and `req_ready` returns high in the next cycle.
- R9: `req_ready` is low from acceptance through the `rd_done` cycle. A request presented then is ignored: it starts no read and does not change the bytes sent.
- R10: `spi_sclk` stays high for exactly CLK_DIV clock cycles per bit, and low for CLK_DIV cycles between bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | 3 | Channel number to convert |
| rd_done | output | 1 | One-cycle pulse when a read ends |
| rd_value | output | 8 | Assembled conversion value |
| rd_err | output | 1 | Reply failed the zero-bit check |
| spi_cs_n | output | 1 | Converter select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to converter |
| spi_miso | input | 1 | Data from converter |

## Verification
The bench builds the block with CLK_DIV=3 and SETUP_CYC=5 instead of the 125-cycle settling default. A full read then takes about 150 cycles, so a short run can cover every channel and each forbidden reply bit. With three-cycle half periods, the mid-bit stability of the data line and the exact high-time of the clock show up as distinct cycles. The small settling count keeps the select-to-first-edge gap measurable against its lower bound.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int WORD_W    = 8;
  localparam int CHAN_W    = 3;
  localparam int NUM_XFERS = 3;

  typedef enum logic [1:0] {RD_IDLE, RD_SETUP, RD_XFER, RD_DONE} rd_state_t;

  // Command word: start bit on top, channel below it, low nibble all ones.
  function automatic logic [WORD_W-1:0] make_ctrl(input logic [CHAN_W-1:0] ch);
    return {1'b1, ch, 4'b1111};
  endfunction

  function automatic logic frame_bad(input logic [WORD_W-1:0] hi_b,
                                     input logic [WORD_W-1:0] lo_b);
    return (hi_b[7:6] != 2'b00) || (lo_b[5:0] != 6'd0);
  endfunction

  function automatic logic [WORD_W-1:0] join_value(input logic [WORD_W-1:0] hi_b,
                                                   input logic [WORD_W-1:0] lo_b);
    return {hi_b[5:0], lo_b[7:6]};
  endfunction
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic [W-1:0] rx_word,
  output logic         byte_done
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  tx_q, rx_q;
  logic [BW-1:0] bit_q;
  logic          sclk_q;
  logic          last_bit;

  assign last_bit  = (bit_q == BW'(W - 1));
  assign byte_done = tick && sclk_q && last_bit;
  assign sclk      = sclk_q;
  assign mosi      = tx_q[W-1];
  assign rx_word   = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (tick && !sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[W-2:0], miso};
      end else if (tick && sclk_q) begin
        sclk_q <= 1'b0;
        bit_q  <= last_bit ? '0 : bit_q + 1'b1;
      end
      if (load)                tx_q <= load_data;
      else if (tick && sclk_q) tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int SETUP_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  output logic              req_ready,
  input  logic              byte_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              tick_run,
  output logic              sh_load,
  output logic [WORD_W-1:0] sh_data,
  output logic              cs_n,
  output logic              done,
  output logic [WORD_W-1:0] value,
  output logic              err
);
  localparam int SCW     = $clog2(SETUP_CYC + 1);
  localparam int IW      = $clog2(NUM_XFERS + 1);
  localparam int HI_IDX  = 1;
  localparam int END_IDX = NUM_XFERS - 1;

  rd_state_t         state;
  logic [SCW-1:0]    scnt;
  logic [IW-1:0]     bidx;
  logic [WORD_W-1:0] hi_q;
  logic              last_byte;

  assign last_byte = (bidx == IW'(END_IDX));
  assign req_ready = (state == RD_IDLE);
  assign tick_run  = (state == RD_XFER);
  assign cs_n      = !((state == RD_SETUP) || (state == RD_XFER));
  assign done      = (state == RD_DONE);
  assign sh_load   = (req_ready && req_valid) || (tick_run && byte_done && !last_byte);
  assign sh_data   = req_ready ? make_ctrl(req_chan) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RD_IDLE;
      scnt  <= '0;
      bidx  <= '0;
      hi_q  <= '0;
      value <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: if (req_valid) begin
          state <= RD_SETUP;
          scnt  <= '0;
        end
        RD_SETUP: begin
          if (scnt == SCW'(SETUP_CYC - 1)) begin
            state <= RD_XFER;
            bidx  <= '0;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        RD_XFER: if (byte_done) begin
          bidx <= bidx + 1'b1;
          if (bidx == IW'(HI_IDX)) hi_q <= rx_word;
          if (last_byte) begin
            err   <= frame_bad(hi_q, rx_word);
            value <= frame_bad(hi_q, rx_word) ? '0 : join_value(hi_q, rx_word);
            state <= RD_DONE;
          end
        end
        RD_DONE: state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_chan_reader.sv
module adc_chan_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int SETUP_CYC = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_chan,
  output logic       rd_done,
  output logic [7:0] rd_value,
  output logic       rd_err,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic              tick, tick_run, byte_done, sh_load;
  logic [WORD_W-1:0] rx_word, sh_data;

  adc_rd_tick #(.DIV(CLK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(tick_run), .tick(tick)
  );

  adc_rd_shifter #(.W(WORD_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(sh_load), .load_data(sh_data),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(rx_word),
    .byte_done(byte_done)
  );

  adc_rd_seq #(.SETUP_CYC(SETUP_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_ready(req_ready), .byte_done(byte_done), .rx_word(rx_word),
    .tick_run(tick_run), .sh_load(sh_load), .sh_data(sh_data), .cs_n(spi_cs_n),
    .done(rd_done), .value(rd_value), .err(rd_err)
  );
endmodule

// File: rtl/adc_chan_reader_chk.sv
module adc_chan_reader_chk #(
  parameter int CLK_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rd_done,
  input logic [7:0] rd_value,
  input logic       rd_err,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi
);
  localparam int HW = $clog2(CLK_DIV + 2);

  logic [HW-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n)        hi_len <= '0;
    else if (spi_sclk) hi_len <= hi_len + 1'b1;
    else               hi_len <= '0;
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_busy_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!spi_cs_n || rd_done));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (!rd_done && req_ready));

  assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> rd_done);

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_err) |-> (rd_value == 8'd0));

  assert_high_time_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> (hi_len == HW'(CLK_DIV)));
endmodule

bind adc_chan_reader adc_chan_reader_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_done(rd_done),
  .rd_value(rd_value), .rd_err(rd_err), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/adc_chan_reader_tb_top.sv
module adc_chan_reader_tb_top;
  localparam int DIV   = 3;
  localparam int SETUP = 5;
  localparam int SPAN  = SETUP + 48 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_chan = 3'd0;
  logic       req_ready, rd_done, rd_err, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic [7:0] rd_value;

  always #4 clk = ~clk;

  adc_chan_reader #(.CLK_DIV(DIV), .SETUP_CYC(SETUP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .rd_done(rd_done), .rd_value(rd_value), .rd_err(rd_err),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // converter model: replies shifted out MSB first, next bit on each falling clock
  logic [7:0]  r1 = 8'h00, r2 = 8'h00, r3 = 8'h00;
  logic [23:0] slv_sh = 24'd0;
  assign spi_miso = slv_sh[23];
  always @(negedge spi_cs_n) slv_sh = {r1, r2, r3};
  always @(negedge spi_sclk) if (!spi_cs_n) slv_sh = slv_sh << 1;

  // line monitor
  logic [23:0] mon_bits = 24'd0;
  int  rises = 0, gap = 0;
  bit  saw_rise = 0;
  always @(posedge spi_sclk) begin
    mon_bits = {mon_bits[22:0], spi_mosi};
    rises++;
    saw_rise = 1;
  end

  // behavioural timeline: 0 idle, 1 selected, 2 done cycle
  int       phase = 0, left = 0;
  bit [2:0] m_ch = 3'd0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) phase = 0;
    else case (phase)
      0: if (req_valid) begin
           phase = 1; left = SPAN; m_ch = req_chan;
           mon_bits = 24'd0; rises = 0; gap = 0; saw_rise = 0;
         end
      1: begin left--; if (left == 0) phase = 2; end
      default: phase = 0;
    endcase
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && req_ready === 1'b1 && rd_done === 1'b0,
            "R1 reset state", {spi_cs_n, spi_sclk, req_ready, rd_done}, 4'b1010);
      end else begin
        if (phase == 1 && !saw_rise && !spi_sclk) gap++;
        chk(req_ready === (phase == 0), "R9 ready", req_ready, phase == 0);
        chk(spi_cs_n === (phase != 1), "R4 select", spi_cs_n, phase != 1);
        chk(rd_done === (phase == 2), "R8 done pulse", rd_done, phase == 2);
        if (phase != 1) chk(spi_sclk === 1'b0, "R4 sclk idle", spi_sclk, 0);
        if (phase == 2) begin
          automatic bit       e_err = (r2[7:6] != 0) || (r3[5:0] != 0);
          automatic bit [7:0] e_val = e_err ? 8'd0 : {r2[5:0], r3[7:6]};
          chk(rd_err === e_err, "R7 error flag", rd_err, e_err);
          chk(rd_value === e_val, "R6 value", rd_value, e_val);
          chk(mon_bits === {1'b1, m_ch, 4'b1111, 16'h0000}, "R2 sent bytes",
              mon_bits, {1'b1, m_ch, 4'b1111, 16'h0000});
          chk(rises == 24, "R3 rising edge count", rises, 24);
          chk(gap >= SETUP, "R5 select setup", gap, SETUP);
          chk(gap == SETUP + DIV, "R10 first half period", gap, SETUP + DIV);
        end
      end
    end
  end

  task automatic do_read(input logic [2:0] ch, input logic [7:0] a, b, c, input bit poke);
    @(negedge clk);
    r1 = a; r2 = b; r3 = c;
    req_chan = ch; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin   // R9: request while busy must be ignored
      req_chan = ~ch; req_valid = 1'b1;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
    end
    while (phase != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);                       // R1 idle holds
    do_read(3'd0, 8'hFF, 8'h3F, 8'hC0, 1'b0);         // R6 full scale
    do_read(3'd5, 8'hA5, 8'h15, 8'h80, 1'b1);         // R6 R9
    do_read(3'd7, 8'h00, 8'h00, 8'h00, 1'b0);         // R6 zero
    do_read(3'd2, 8'h5A, 8'h80, 8'h40, 1'b0);         // R7 bit7 of second
    do_read(3'd3, 8'h00, 8'h41, 8'h00, 1'b1);         // R7 bit6 of second
    do_read(3'd1, 8'hFF, 8'h2A, 8'h41, 1'b0);         // R7 bit0 of third
    do_read(3'd4, 8'h12, 8'h01, 8'h20, 1'b0);         // R7 bit5 of third
    do_read(3'd6, 8'hC3, 8'h2B, 8'h40, 1'b0);         // R6 R2
    for (int k = 0; k < 8; k++)
      do_read(3'(k), 8'(k * 37), 8'(k * 5) & 8'h3F, 8'(k << 6), 1'b0);   // R2 channel sweep
    finish_run();
  end

  initial begin
    while (cyc < 100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule